// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software liveness on a chip. Once software turns it on, a down-counter starts from a programmed timeout and loses one step every clock. Software proves it is alive by writing a fixed key to a refresh address. That refresh only counts while the counter sits inside a window near the bottom of its range. A refresh that comes too early is treated as a failure, and so is a wrong key value or letting the counter run out. This stops a runaway tight loop from keeping the block satisfied.

Before the counter runs out, a level interrupt warns software so that diagnostics can run. On any failure the block stops counting. It then raises a reset request for a fixed number of clocks and drives an external fault pin. It records which failure occurred in a field that only the block reset clears.

Configuration goes through a small write port, and a combinational read port returns status, settings and the live count. Once the block is on, it cannot be turned off, and its timing settings are locked.

Top module: `win_watchdog`

## Requirements
- R1: After rst_ni the outputs are low, status reads 0, the count reads 0, and timeout, window and warning threshold read their parameter defaults (1000, 250 and 500).
- R2: Writing 1 to ctrl bit 0 (address 0) loads the count from the timeout, and the count then drops by one per clock. Writing 0 to bit 0 afterwards has no effect.
- R3: While enabled, writes to timeout (address 1), window (address 2) and warning threshold (address 3) are ignored.
- R4: A write of the key 16'hC35A to address 4, made while the count is nonzero and at most the window value, reloads the timeout in the next cycle.
- R5: The key written while the count is above the window is a fault with cause 2.
- R6: Any other value written to address 4 while running is a fault with cause 3.
- R7: A count of 0 while running is a fault with cause 1 at the next edge.
- R8: warn_irq_o rises the cycle after the count equals the warning threshold. It stays high until ctrl bit 1 is written as 1 or a valid refresh reloads the count.
- R9: After a fault, sys_rst_req_o is high for exactly 16 cycles, fault_pin_o stays high, and the count freezes. Later refresh writes are ignored until rst_ni.
- R10: The cause field is sticky: once set, only rst_ni clears it.
- R11: Writes to address 4 while disabled are ignored and cause no fault.
- R12: Readback: address 0 gives {cause[4:3], halted[2], warning[1], enable[0]}, addresses 1 to 3 give the settings, and address 4 gives the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous full reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| warn_irq_o | output | 1 | Early-warning interrupt, level |
| sys_rst_req_o | output | 1 | System reset request pulse |
| fault_pin_o | output | 1 | External fault pin |

## Verification
The bench targets the window edges.

A refresh at a count equal to the window must reload the counter, while one step higher must fault as early. A design off by one there would either reject a legal refresh or let an early one through.

The bench also checks the following:
- Enable, configuration writes and a clearing write to the enable bit arrive after locking. A broken lock would let software stretch the timeout.
- The reset pulse length, which a miscounted stretcher would make 15 or 17 cycles long.
- A refresh after a fault must not revive the counter or overwrite the recorded cause.
- The warning clears on a refresh as well as on an explicit clear.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_EXPIRE = 2'd1,
    CAUSE_EARLY  = 2'd2,
    CAUSE_KEY    = 2'd3
  } cause_e;

  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_TIMEOUT = 3'd1;
  localparam logic [2:0] ADDR_WINDOW  = 3'd2;
  localparam logic [2:0] ADDR_WARN    = 3'd3;
  localparam logic [2:0] ADDR_KICK    = 3'd4;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned CNT_W       = 16,
  parameter logic [DW-1:0] KEY       = 16'hC35A,
  parameter int unsigned DEF_TIMEOUT = 1000,
  parameter int unsigned DEF_WINDOW  = 250,
  parameter int unsigned DEF_WARN    = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             en_o,
  output logic             en_set_o,
  output logic [CNT_W-1:0] timeout_o,
  output logic [CNT_W-1:0] window_o,
  output logic [CNT_W-1:0] warn_thr_o,
  output logic             kick_wr_o,
  output logic             key_ok_o,
  output logic             warn_clr_o
);
  logic             en_q;
  logic [CNT_W-1:0] timeout_q, window_q, warn_q;
  logic             ctrl_wr;

  assign ctrl_wr    = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign en_set_o   = ctrl_wr && wr_data_i[0] && !en_q;
  assign warn_clr_o = ctrl_wr && wr_data_i[1];
  assign kick_wr_o  = wr_en_i && (wr_addr_i == ADDR_KICK);
  assign key_ok_o   = (wr_data_i == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      timeout_q <= CNT_W'(DEF_TIMEOUT);
      window_q  <= CNT_W'(DEF_WINDOW);
      warn_q    <= CNT_W'(DEF_WARN);
    end else begin
      if (en_set_o) en_q <= 1'b1;
      if (wr_en_i && !en_q) begin
        if (wr_addr_i == ADDR_TIMEOUT) timeout_q <= wr_data_i[CNT_W-1:0];
        if (wr_addr_i == ADDR_WINDOW)  window_q  <= wr_data_i[CNT_W-1:0];
        if (wr_addr_i == ADDR_WARN)    warn_q    <= wr_data_i[CNT_W-1:0];
      end
    end
  end

  assign en_o       = en_q;
  assign timeout_o  = timeout_q;
  assign window_o   = window_q;
  assign warn_thr_o = warn_q;

  assert_en_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  assert_cfg_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> ($stable(timeout_q) && $stable(window_q) && $stable(warn_q)));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_set_i,
  input  logic             running_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic [CNT_W-1:0] window_i,
  input  logic [CNT_W-1:0] warn_thr_i,
  input  logic             kick_wr_i,
  input  logic             key_ok_i,
  input  logic             warn_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             warn_o,
  output logic             fault_vld_o,
  output cause_e           fault_code_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             warn_q;
  logic             reload;
  logic             at_zero, in_window;

  assign at_zero   = (cnt_q == '0);
  assign in_window = (cnt_q <= window_i);
  assign reload    = running_i && kick_wr_i && key_ok_i && !at_zero && in_window;

  always_comb begin
    fault_code_o = CAUSE_NONE;
    if (running_i) begin
      if (at_zero)        fault_code_o = CAUSE_EXPIRE;
      else if (kick_wr_i) begin
        if (!key_ok_i)       fault_code_o = CAUSE_KEY;
        else if (!in_window) fault_code_o = CAUSE_EARLY;
      end
    end
  end
  assign fault_vld_o = (fault_code_o != CAUSE_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      if (en_set_i)                       cnt_q <= timeout_i;
      else if (running_i && !fault_vld_o) cnt_q <= reload ? timeout_i : cnt_q - CNT_W'(1);
      // reload beats a new warning; a new warning beats a software clear
      if (reload)                                                   warn_q <= 1'b0;
      else if (running_i && !fault_vld_o && cnt_q == warn_thr_i)    warn_q <= 1'b1;
      else if (warn_clr_i)                                          warn_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign warn_o = warn_q;

  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && !kick_wr_i && cnt_q != '0 && !en_set_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && kick_wr_i && key_ok_i && cnt_q != '0 && cnt_q <= window_i) |=> cnt_q == $past(timeout_i));
  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_i && !en_set_i) |=> $stable(cnt_q));
  assert_warn_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_q) |-> $past(cnt_q) == $past(warn_thr_i));
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
  import wdg_pkg::*;
#(
  parameter int unsigned RST_HOLD = 16,
  localparam int unsigned HOLD_W  = $clog2(RST_HOLD + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fault_vld_i,
  input  cause_e fault_code_i,
  output logic   halted_o,
  output cause_e cause_o,
  output logic   rst_req_o
);
  logic              halted_q;
  cause_e            cause_q;
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
      hold_q   <= '0;
    end else if (fault_vld_i && !halted_q) begin
      halted_q <= 1'b1;
      cause_q  <= fault_code_i;
      hold_q   <= HOLD_W'(RST_HOLD);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - HOLD_W'(1);
    end
  end

  assign halted_o  = halted_q;
  assign cause_o   = cause_q;
  assign rst_req_o = (hold_q != '0);

  assert_cause_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && $stable(cause_q)));
  assert_req_in_halt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> halted_q);
  assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_vld_i && !halted_q) |=> (cause_q == $past(fault_code_i) && rst_req_o));
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned CNT_W       = 16,
  parameter logic [DW-1:0] KEY       = 16'hC35A,
  parameter int unsigned DEF_TIMEOUT = 1000,
  parameter int unsigned DEF_WINDOW  = 250,
  parameter int unsigned DEF_WARN    = 500,
  parameter int unsigned RST_HOLD    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [2:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          warn_irq_o,
  output logic          sys_rst_req_o,
  output logic          fault_pin_o
);
  logic             en, en_set, kick_wr, key_ok, warn_clr, warn, halted, fault_vld, running;
  logic [CNT_W-1:0] timeout, window, warn_thr, cnt;
  cause_e           fault_code, cause;

  wdg_regs #(
    .DW(DW), .CNT_W(CNT_W), .KEY(KEY),
    .DEF_TIMEOUT(DEF_TIMEOUT), .DEF_WINDOW(DEF_WINDOW), .DEF_WARN(DEF_WARN)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en), .en_set_o(en_set), .timeout_o(timeout), .window_o(window),
    .warn_thr_o(warn_thr), .kick_wr_o(kick_wr), .key_ok_o(key_ok), .warn_clr_o(warn_clr)
  );

  assign running = en && !halted;

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_set_i(en_set), .running_i(running),
    .timeout_i(timeout), .window_i(window), .warn_thr_i(warn_thr),
    .kick_wr_i(kick_wr), .key_ok_i(key_ok), .warn_clr_i(warn_clr),
    .cnt_o(cnt), .warn_o(warn), .fault_vld_o(fault_vld), .fault_code_o(fault_code)
  );

  wdg_escalate #(.RST_HOLD(RST_HOLD)) u_esc (
    .clk_i, .rst_ni, .fault_vld_i(fault_vld), .fault_code_i(fault_code),
    .halted_o(halted), .cause_o(cause), .rst_req_o(sys_rst_req_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CTRL:    rd_data_o[4:0] = {cause, halted, warn, en};
      ADDR_TIMEOUT: rd_data_o[CNT_W-1:0] = timeout;
      ADDR_WINDOW:  rd_data_o[CNT_W-1:0] = window;
      ADDR_WARN:    rd_data_o[CNT_W-1:0] = warn_thr;
      ADDR_KICK:    rd_data_o[CNT_W-1:0] = cnt;
      default:      rd_data_o = '0;
    endcase
  end

  assign warn_irq_o  = warn;
  assign fault_pin_o = halted;

  assert_pin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pin_o |=> fault_pin_o);
endmodule

// File: tb/win_watchdog_tb_top.sv
module win_watchdog_tb_top;
  localparam int KEY = 16'hC35A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        warn_irq_o, sys_rst_req_o, fault_pin_o;

  int n_vec = 0, n_bad = 0, cyc = 0;
  // reference model state
  int m_en, m_to, m_win, m_wth, m_cnt, m_warn, m_halt, m_cause, m_hold;

  always #5 clk_i = ~clk_i;

  win_watchdog dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_defaults();
    m_en = 0; m_to = 1000; m_win = 250; m_wth = 500; m_cnt = 0;
    m_warn = 0; m_halt = 0; m_cause = 0; m_hold = 0;
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return (m_cause << 3) | (m_halt << 2) | (m_warn << 1) | m_en;
      1: return m_to;
      2: return m_win;
      3: return m_wth;
      4: return m_cnt;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, advanced at each rising edge, compared 2 ns later
  always @(posedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      int run, fcode, rel, kick, nw;
      run = m_en && !m_halt;
      kick = wr_en_i && wr_addr_i == 4;
      fcode = 0; rel = 0;
      if (run) begin
        if (m_cnt == 0) fcode = 1;
        else if (kick) begin
          if (wr_data_i != KEY) fcode = 3;
          else if (m_cnt > m_win) fcode = 2;
          else rel = 1;
        end
      end
      nw = m_warn;
      if (rel) nw = 0;
      else if (run && fcode == 0 && m_cnt == m_wth) nw = 1;
      else if (wr_en_i && wr_addr_i == 0 && wr_data_i[1]) nw = 0;
      if (fcode != 0) begin
        m_halt = 1; m_cause = fcode; m_hold = 16;
      end else if (m_hold > 0) m_hold--;
      if (run && fcode == 0) m_cnt = rel ? m_to : m_cnt - 1;
      if (wr_en_i && !m_en) begin
        if (wr_addr_i == 1) m_to = wr_data_i;
        if (wr_addr_i == 2) m_win = wr_data_i;
        if (wr_addr_i == 3) m_wth = wr_data_i;
        if (wr_addr_i == 0 && wr_data_i[0]) begin m_en = 1; m_cnt = m_to; end
      end
      m_warn = nw;
    end
    #2;
    chk("R8 warn_irq", warn_irq_o, m_warn);
    chk("R9 sys_rst_req", sys_rst_req_o, m_hold > 0);
    chk("R9 fault_pin", fault_pin_o, m_halt);
    chk("R12 readback", rd_data_o, exp_rd(rd_addr_i));
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    wr_en_i = 1; wr_addr_i = 3'(a); wr_data_i = 16'(d);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(int a, output int v);
    rd_addr_i = 3'(a); #1; v = rd_data_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; model_defaults();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic wait_cnt(int v);
    while (m_cnt != v && !m_halt) @(negedge clk_i);
  endtask

  task automatic setup_en();
    wr(1, 40); wr(2, 15); wr(3, 25); wr(0, 1);
  endtask

  initial begin
    int v, n;
    model_defaults();
    do_reset();
    // R1 reset state
    rd(0, v); chk("R1 status", v, 0);
    rd(4, v); chk("R1 count", v, 0);
    rd(1, v); chk("R1 timeout", v, 1000);
    rd(2, v); chk("R1 window", v, 250);
    rd(3, v); chk("R1 warn thr", v, 500);
    chk("R1 rst_req", sys_rst_req_o, 0);
    // R11 refresh while disabled
    wr(4, KEY); wr(4, 16'h1234);
    rd(0, v); chk("R11 no fault", v, 0);
    rd(4, v); chk("R11 count", v, 0);
    setup_en();
    rd(4, v); chk("R2 load", v, 40);
    @(negedge clk_i); rd(4, v); chk("R2 dec", v, 39);
    wr(1, 99); wr(3, 7);
    rd(1, v); chk("R3 timeout locked", v, 40);
    rd(3, v); chk("R3 warn locked", v, 25);
    wr(0, 0);
    rd(0, v); chk("R2 enable stays", v & 1, 1);
    // window boundary: refresh at count == window is valid
    wait_cnt(15);
    chk("R8 warn before refresh", warn_irq_o, 1);
    wr(4, KEY);
    rd(4, v); chk("R4 reload at window edge", v, 40);
    chk("R8 cleared by refresh", warn_irq_o, 0);
    wait_cnt(20);
    chk("R8 warn raised", warn_irq_o, 1);
    wr(0, 2);
    chk("R8 cleared by sw", warn_irq_o, 0);
    rd(0, v); chk("R8 status", v, 1);
    // let it expire
    wait_cnt(-1);
    rd(0, v); chk("R7 cause expire", v >> 3, 1);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      if (sys_rst_req_o) n++;
      @(negedge clk_i);
    end
    chk("R9 pulse length", n, 16);
    rd(4, v);
    wr(4, KEY); wr(0, 1);
    rd(4, n); chk("R9 count frozen", n, v);
    rd(0, v); chk("R10 cause kept", v >> 3, 1);
    chk("R9 pin held", fault_pin_o, 1);

    // early refresh at window+1
    do_reset();
    rd(0, v); chk("R10 cleared by reset", v, 0);
    setup_en();
    wait_cnt(16);
    wr(4, KEY);
    rd(0, v); chk("R5 cause early", v >> 3, 2);
    chk("R9 pin", fault_pin_o, 1);

    // bad key
    do_reset();
    setup_en();
    wait_cnt(10);
    wr(4, KEY ^ 1);
    rd(0, v); chk("R6 cause key", v >> 3, 3);
    wr(0, 3);
    rd(0, v); chk("R10 cause sticky", v >> 3, 3);
    repeat (20) @(negedge clk_i);
    chk("R9 req ended", sys_rst_req_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule